// File: doc/BRIEF.md
# User-Requested Refresh Arbiter

This block sits in the command scheduler of a DRAM controller and inserts refresh commands that the user asks for. The user raises a request line and selects one or more ranks on a chip-select vector. The arbiter then holds back queued reads and writes and issues a refresh to the selected ranks. It gives one acknowledge pulse for each refresh it issues. While the request stays high it keeps refreshing.

Three things can delay a refresh. A rank that is in self-refresh is removed from the target set. Each rank must wait out its refresh cycle time after its previous refresh. A run of back-to-back refreshes is capped at nine, after which the queue gets one free slot before refreshing resumes. A request that selects no rank is ignored.

Everything runs on the controller's interface clock. The refresh command, the acknowledge and the stall are combinational in the current request, so the scheduler sees them in the same slot in which they are decided.

Top module: `usr_refresh_arb`

## Requirements
- R1: When `refReq` is high and the effective mask (`refRankSel` AND NOT `rankInSelfRef`) is non-zero and every rank in that mask is ready, `refCmdValid` is high and `refCmdRanks` equals the effective mask. Bit i of each vector is rank i.
- R2: While a refresh is pending, `queueStall` equals `queueNotEmpty`. Pending means the request is high, the effective mask is non-zero and no burst release slot is active. This holds whether or not the command can issue in that cycle. When nothing is pending, `queueStall` is low.
- R3: With `refReq` held, another refresh is issued as soon as the target ranks are ready again. With `refReq` low, no command is issued.
- R4: After the ninth refresh within one held request, the next cycle issues no command and has `queueStall` low. Counting then restarts from zero. The count also resets whenever `refReq` is low for a cycle.
- R5: Ranks in self-refresh never receive a refresh command. If masking leaves no rank, the request waits: no command, no acknowledge and no stall.
- R6: A rank receives a new refresh no earlier than `REFRESH_CYCLES` cycles after its previous refresh. If any rank in the effective mask is not ready yet, the whole command waits.
- R7: A request with an all-zero `refRankSel` issues no command, no acknowledge and no stall.
- R8: `refAck` is a single-cycle strobe, high exactly in each cycle a refresh command is issued.
- R9: After reset all outputs are low with the request low, and every rank is ready, so the first request issues in its first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refReq | input | 1 | User refresh request, level held |
| refRankSel | input | NUM_RANKS | Ranks to refresh |
| queueNotEmpty | input | 1 | Read/write command queue has entries |
| rankInSelfRef | input | NUM_RANKS | Per-rank self-refresh status |
| refCmdValid | output | 1 | Refresh command issued this cycle |
| refCmdRanks | output | NUM_RANKS | Ranks addressed by the refresh command |
| queueStall | output | 1 | Hold the read/write queue this cycle |
| refAck | output | 1 | One pulse per refresh issued |

## Verification
The refresh cycle-time hold-off on a rank and the one-cycle release after the ninth refresh can fall in the same cycle. The bench provokes this by holding a single-rank request with the queue busy. The ninth refresh then lands while that rank is still timing out, so the release slot coincides with a cycle that would otherwise stall without issuing. The check is that the stall drops for exactly that one cycle and the command cadence is unchanged. A rotating-rank run separates the two effects: there the release slot is the only cycle without a command.

// File: rtl/uref_pkg.sv
package urefPkg;
  typedef struct packed {
    logic issue;       // a refresh command goes out this cycle
    logic clearBurst;  // request low: restart the consecutive count
  } refStrobe_t;
endpackage

// File: rtl/uref_datapath.sv
module urefDatapath
  import urefPkg::*;
#(
  parameter int NUM_RANKS      = 4,
  parameter int REFRESH_CYCLES = 64,
  parameter int MAX_BURST      = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  refStrobe_t           strobe,
  input  logic [NUM_RANKS-1:0] issueMask,
  output logic [NUM_RANKS-1:0] busyMask,
  output logic                 coolActive
);
  localparam int TIMER_W = $clog2(REFRESH_CYCLES + 1);
  localparam int BURST_W = $clog2(MAX_BURST + 1);
  localparam logic [TIMER_W-1:0] RELOAD   = TIMER_W'(REFRESH_CYCLES - 1);
  localparam logic [BURST_W-1:0] LAST_CNT = BURST_W'(MAX_BURST - 1);

  // per-rank refresh cycle-time counters
  for (genvar g = 0; g < NUM_RANKS; g++) begin : gRankTimer
    logic [TIMER_W-1:0] remain;
    always_ff @(posedge clk) begin
      if (!rst_n)                          remain <= '0;
      else if (strobe.issue && issueMask[g]) remain <= RELOAD;
      else if (remain != '0)               remain <= remain - 1'b1;
    end
    assign busyMask[g] = (remain != '0);
  end

  // consecutive refresh counter and release slot
  logic [BURST_W-1:0] burstCnt;
  logic               lastOfBurst;
  assign lastOfBurst = (burstCnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n)                burstCnt <= '0;
    else if (strobe.clearBurst) burstCnt <= '0;
    else if (strobe.issue)     burstCnt <= lastOfBurst ? '0 : burstCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) coolActive <= 1'b0;
    else        coolActive <= strobe.issue && lastOfBurst && !strobe.clearBurst;
  end
endmodule

// File: rtl/uref_control.sv
module urefControl
  import urefPkg::*;
#(
  parameter int NUM_RANKS = 4
) (
  input  logic                 refReq,
  input  logic [NUM_RANKS-1:0] refRankSel,
  input  logic [NUM_RANKS-1:0] rankInSelfRef,
  input  logic                 queueNotEmpty,
  input  logic [NUM_RANKS-1:0] busyMask,
  input  logic                 coolActive,
  output refStrobe_t           strobe,
  output logic [NUM_RANKS-1:0] cmdMask,
  output logic                 stallOut
);
  logic [NUM_RANKS-1:0] target;
  logic pending;
  logic ranksReady;

  always_comb begin
    target     = refRankSel & ~rankInSelfRef;
    pending    = refReq && (target != '0) && !coolActive;
    ranksReady = ((target & busyMask) == '0);
    strobe.issue      = pending && ranksReady;
    strobe.clearBurst = !refReq;
    cmdMask  = strobe.issue ? target : '0;
    stallOut = pending && queueNotEmpty;
  end
endmodule

// File: rtl/usr_refresh_arb.sv
module usr_refresh_arb
  import urefPkg::*;
#(
  parameter int NUM_RANKS      = 4,
  parameter int REFRESH_CYCLES = 64,
  parameter int MAX_BURST      = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 refReq,
  input  logic [NUM_RANKS-1:0] refRankSel,
  input  logic                 queueNotEmpty,
  input  logic [NUM_RANKS-1:0] rankInSelfRef,
  output logic                 refCmdValid,
  output logic [NUM_RANKS-1:0] refCmdRanks,
  output logic                 queueStall,
  output logic                 refAck
);
  refStrobe_t           strobe;
  logic [NUM_RANKS-1:0] busyMask;
  logic                 coolActive;

  urefControl #(.NUM_RANKS(NUM_RANKS)) uCtrl (
    .refReq        (refReq),
    .refRankSel    (refRankSel),
    .rankInSelfRef (rankInSelfRef),
    .queueNotEmpty (queueNotEmpty),
    .busyMask      (busyMask),
    .coolActive    (coolActive),
    .strobe        (strobe),
    .cmdMask       (refCmdRanks),
    .stallOut      (queueStall)
  );

  urefDatapath #(
    .NUM_RANKS      (NUM_RANKS),
    .REFRESH_CYCLES (REFRESH_CYCLES),
    .MAX_BURST      (MAX_BURST)
  ) uData (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .issueMask  (refCmdRanks),
    .busyMask   (busyMask),
    .coolActive (coolActive)
  );

  assign refCmdValid = strobe.issue;
  assign refAck      = strobe.issue;
endmodule

// File: rtl/uref_checker.sv
module urefChecker #(
  parameter int NUM_RANKS      = 4,
  parameter int REFRESH_CYCLES = 64,
  parameter int MAX_BURST      = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 refReq,
  input logic [NUM_RANKS-1:0] refRankSel,
  input logic                 queueNotEmpty,
  input logic [NUM_RANKS-1:0] rankInSelfRef,
  input logic                 refCmdValid,
  input logic [NUM_RANKS-1:0] refCmdRanks,
  input logic                 queueStall,
  input logic                 refAck
);
  localparam int GAP_W = $clog2(REFRESH_CYCLES + 1);
  localparam int CNT_W = $clog2(MAX_BURST + 1);

  logic [CNT_W-1:0] issueCnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !refReq) issueCnt <= '0;
    else if (refCmdValid)  issueCnt <= (issueCnt == CNT_W'(MAX_BURST - 1)) ? '0 : issueCnt + 1'b1;
  end

  AST_CMD_IN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    refCmdValid |-> (refCmdRanks != '0) && ((refCmdRanks & ~refRankSel) == '0)); // R1
  AST_STALL_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (refCmdValid && queueNotEmpty) |-> queueStall); // R2
  AST_NO_REQ_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !refReq |-> (!refCmdValid && !queueStall)); // R3
  AST_BURST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (refReq && refCmdValid && issueCnt == CNT_W'(MAX_BURST - 1)) |=> (!refCmdValid && !queueStall)); // R4
  AST_NO_SELFREF: assert property (@(posedge clk) disable iff (!rst_n)
    refCmdValid |-> ((refCmdRanks & rankInSelfRef) == '0)); // R5
  AST_ZERO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (refRankSel == '0) |-> (!refCmdValid && !refAck && !queueStall)); // R7
  AST_ACK_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    refAck |-> refCmdValid); // R8

  for (genvar g = 0; g < NUM_RANKS; g++) begin : gGap
    logic [GAP_W-1:0] gap;
    always_ff @(posedge clk) begin
      if (!rst_n)                                gap <= GAP_W'(REFRESH_CYCLES);
      else if (refCmdValid && refCmdRanks[g])    gap <= GAP_W'(1);
      else if (gap < GAP_W'(REFRESH_CYCLES))     gap <= gap + 1'b1;
    end
    AST_TRFC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (refCmdValid && refCmdRanks[g]) |-> (gap == GAP_W'(REFRESH_CYCLES))); // R6
  end
endmodule

bind usr_refresh_arb urefChecker #(
  .NUM_RANKS      (NUM_RANKS),
  .REFRESH_CYCLES (REFRESH_CYCLES),
  .MAX_BURST      (MAX_BURST)
) uChk (
  .clk           (clk),
  .rst_n         (rst_n),
  .refReq        (refReq),
  .refRankSel    (refRankSel),
  .queueNotEmpty (queueNotEmpty),
  .rankInSelfRef (rankInSelfRef),
  .refCmdValid   (refCmdValid),
  .refCmdRanks   (refCmdRanks),
  .queueStall    (queueStall),
  .refAck        (refAck)
);

// File: tb/sim_usr_refresh_arb.sv
module sim_usr_refresh_arb;
  localparam int NR = 3;
  localparam int TR = 3;
  localparam int MB = 9;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          refReq;
  logic [NR-1:0] refRankSel;
  logic          queueNotEmpty;
  logic [NR-1:0] rankInSelfRef;
  logic          refCmdValid;
  logic [NR-1:0] refCmdRanks;
  logic          queueStall;
  logic          refAck;

  usr_refresh_arb #(.NUM_RANKS(NR), .REFRESH_CYCLES(TR), .MAX_BURST(MB)) u0 (
    .clk(clk), .rst_n(rst_n), .refReq(refReq), .refRankSel(refRankSel),
    .queueNotEmpty(queueNotEmpty), .rankInSelfRef(rankInSelfRef),
    .refCmdValid(refCmdValid), .refCmdRanks(refCmdRanks),
    .queueStall(queueStall), .refAck(refAck)
  );

  int nRun = 0;
  int nFail = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nextCycle();
    @(posedge clk); #1;
  endtask

  task automatic rest();
    refReq = 1'b0;
    repeat (TR + 1) nextCycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; refReq = 1'b0; refRankSel = '0; queueNotEmpty = 1'b0; rankInSelfRef = '0;
    repeat (3) nextCycle();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset cmd",   refCmdValid, 0);
    chk("R9 reset stall", queueStall, 0);
    chk("R9 reset ack",   refAck, 0);
    nextCycle();
    refReq = 1'b1; refRankSel = 3'b101; queueNotEmpty = 1'b1;
    @(negedge clk);
    chk("R9 first request issues", refCmdValid, 1);
    chk("R9 first request ranks", refCmdRanks, 5);
    nextCycle();
    rest();

    // sweep: every select x self-refresh x queue combination (R1 R2 R5 R7 R8)
    for (int s = 0; s < (1 << NR); s++)
      for (int f = 0; f < (1 << NR); f++)
        for (int q = 0; q < 2; q++) begin
          int tgt;
          tgt = s & ~f & ((1 << NR) - 1);
          refReq = 1'b1; refRankSel = NR'(s); rankInSelfRef = NR'(f); queueNotEmpty = q[0];
          @(negedge clk);
          if (s == 0) chk("R7 zero select no cmd", refCmdValid, 0);
          chk("R1 cmd valid",  refCmdValid, (tgt != 0) ? 1 : 0);
          chk("R5 masked ranks", refCmdRanks, tgt);
          chk("R8 ack with cmd", refAck, (tgt != 0) ? 1 : 0);
          chk("R2 stall", queueStall, (tgt != 0 && q == 1) ? 1 : 0);
          nextCycle();
          rest();
        end
    rankInSelfRef = '0;

    // single rank held: tRFC cadence with burst release inside a hold-off
    refReq = 1'b1; refRankSel = 3'b001; queueNotEmpty = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      chk("R3 R6 held cadence", refCmdValid, (k % TR == 0) ? 1 : 0);
      chk("R4 release in hold-off", queueStall, (k == 25) ? 0 : 1);
      nextCycle();
    end
    rest();

    // wait for all target ranks to be ready (R6)
    refReq = 1'b1; refRankSel = 3'b001;
    @(negedge clk);
    chk("R6 first issue", refCmdValid, 1);
    nextCycle();
    refRankSel = 3'b011;
    for (int k = 1; k <= TR; k++) begin
      @(negedge clk);
      chk("R6 whole mask waits", refCmdValid, (k == TR) ? 1 : 0);
      chk("R2 stall while waiting", queueStall, 1);
      if (k == TR) chk("R6 joint ranks", refCmdRanks, 3);
      nextCycle();
    end
    rest();

    // rotating ranks: one refresh per cycle, release after nine (R4)
    refReq = 1'b1;
    for (int k = 0; k < 30; k++) begin
      refRankSel = NR'(1 << (k % NR));
      @(negedge clk);
      chk("R4 burst cap cmd",   refCmdValid, ((k + 1) % (MB + 1) != 0) ? 1 : 0);
      chk("R4 burst cap stall", queueStall,  ((k + 1) % (MB + 1) != 0) ? 1 : 0);
      nextCycle();
    end
    rest();

    // counter restarts when request drops (R4, R3)
    for (int k = 0; k < 20; k++) begin
      refReq = (k != 5);
      refRankSel = NR'(1 << (k % NR));
      @(negedge clk);
      if (k == 5) chk("R3 dropped request", refCmdValid, 0);
      else chk("R4 count restart", refCmdValid, (k == 15) ? 0 : 1);
      nextCycle();
    end
    rest();

    // all selected ranks in self-refresh: wait, then go when one leaves (R5)
    refReq = 1'b1; refRankSel = 3'b011; rankInSelfRef = 3'b011;
    @(negedge clk);
    chk("R5 all masked no cmd", refCmdValid, 0);
    chk("R5 all masked no stall", queueStall, 0);
    nextCycle();
    rankInSelfRef = 3'b001;
    @(negedge clk);
    chk("R5 resumes on exit", refCmdRanks, 2);
    nextCycle();
    rest();

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule